// File: doc/BRIEF.md
# Two-Level Vectored Interrupt Controller

This block arbitrates eight interrupt sources for a small 8-bit processor core. Each source owns a pending flag, an enable bit, a priority bit and an auto-clear bit. A single global enable gates every request. At each instruction boundary the CPU asks the block whether to divert. If the block says yes, it also supplies the call address in the same cycle. It keeps a two-entry record of the priority levels now in service, so a high-priority source can interrupt a low-priority handler but nothing can interrupt a high-priority one.

Software reaches the flags and control bits through a small register port: a selector, a write strobe, write data and a combinational read bus. Peripheral events arrive as one-cycle pulses on `srcEvent`. The CPU supplies three signals: `instBoundary` marks the cycle in which an instruction completes, `nextMulti` says that the following instruction takes more than one cycle, and `retStrobe` marks the completion of a return-from-interrupt. `retStrobe` is always given in a cycle that is also a boundary.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset, all pending, enable, priority and auto-clear bits, the global enable and `inService` are 0, and `irqTake` is 0.
- R2: A pulse on `srcEvent[n]` sets pending bit n whether or not the source is enabled. The bit stays set while the source is disabled, and no take occurs for it.
- R3: `irqTake` is asserted only in a cycle with `instBoundary` high. It requires a source whose pending bit, enable bit and global enable are all 1. With global enable 0 and no open clear window (R10), no source is taken.
- R4: Writing selector 0 loads the pending register from the write data. A bit written to 1 behaves exactly like a hardware event for that source.
- R5: `irqVector` equals 0x0003 + 8·n for the selected source n. Among allowed requests, high priority beats low priority, and within a level the lowest index wins.
- R6: When source n is taken and its auto-clear bit is 1, its pending bit clears on that edge. When the auto-clear bit is 0, the pending bit stays set.
- R7: `inService[0]` marks a low-level handler and `inService[1]` a high-level one. A high request may be taken while only bit 0 is set. No request is taken while bit 1 is set. A low request is not taken while bit 0 is set.
- R8: Each take sets the in-service bit of its level. Each `retStrobe` clears the most recent level: bit 1 if it is set, otherwise bit 0.
- R9: No take happens in a `retStrobe` cycle. A request that is still pending and enabled is taken at the next boundary.
- R10: A write that clears a set global enable leaves one window: at the first boundary at or after the clearing write, requests are still allowed if `nextMulti` is 0 and suppressed if it is 1. At later boundaries the requests are masked.
- R11: The register selectors are 0 pending, 1 enable, 2 priority (1 = high), 3 auto-clear, and 4 global enable in bit 0. The read bus returns the selected register combinationally, and other selector values read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| srcEvent | input | NUM_SRC | One-cycle event pulses, one per source |
| regWr | input | 1 | Register write strobe |
| regSel | input | 3 | Register selector |
| regWrData | input | NUM_SRC | Register write data |
| regRdData | output | NUM_SRC | Selected register contents |
| instBoundary | input | 1 | Current instruction completes this cycle |
| nextMulti | input | 1 | Following instruction is multi-cycle |
| retStrobe | input | 1 | Return-from-interrupt completes this cycle |
| irqTake | output | 1 | CPU must call the vector now |
| irqVector | output | ADDR_W | Call address of the selected source |
| inService | output | 2 | In-service levels: bit 1 high, bit 0 low |

## Verification
The bench builds the controller with its default parameters: eight sources, a 16-bit vector, base 0x0003 and stride 8. This puts every vector from 0x0003 to 0x003B within reach, as well as both priority levels at once. Scenarios drive the two nesting depths, both outcomes of the global-clear window, a clear that lands on a boundary, and the boundary right after a return. These are the orderings where a single-cycle slip changes whether a take happens.

// File: rtl/vic_pkg.sv
package vic_pkg;
  typedef enum logic [2:0] {
    SEL_PEND   = 3'd0,
    SEL_EN     = 3'd1,
    SEL_PRIO   = 3'd2,
    SEL_AUTO   = 3'd3,
    SEL_GLOBAL = 3'd4
  } vicSel_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic take;
    logic useHi;
  } vicStb_t;
endpackage

// File: rtl/vic_pick.sv
module vic_pick #(
  parameter int WIDTH = 8,
  parameter int IW    = 3
) (
  input  logic [WIDTH-1:0] reqVec,
  output logic             found,
  output logic [IW-1:0]    idx
);
  always_comb begin
    found = |reqVec;
    idx   = '0;
    for (int k = WIDTH - 1; k >= 0; k--) begin
      if (reqVec[k]) idx = IW'(k);
    end
  end
endmodule

// File: rtl/vic_datapath.sv
module vic_datapath
  import vic_pkg::*;
#(
  parameter int NUM_SRC    = 8,
  parameter int ADDR_W     = 16,
  parameter int VEC_BASE   = 3,
  parameter int VEC_STRIDE = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] srcEvent,
  input  logic               regWr,
  input  logic [2:0]         regSel,
  input  logic [NUM_SRC-1:0] regWrData,
  output logic [NUM_SRC-1:0] regRdData,
  input  logic               gateOpen,
  input  vicStb_t            stb,
  output logic               hiAny,
  output logic               loAny,
  output logic               glbNow,
  output logic               glbClearing,
  output logic               glbSetting,
  output logic [ADDR_W-1:0]  irqVector
);
  localparam int IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;

  logic [NUM_SRC-1:0] pend, pendNext, enable, prio, autoClr;
  logic               globalEn;
  logic [NUM_SRC-1:0] hiReq, loReq, clrHit;
  logic [IDX_W-1:0]   hiIdx, loIdx, selIdx;
  logic               wrPend, wrEn, wrPrio, wrAuto, wrGlb;

  assign wrPend = regWr && (regSel == SEL_PEND);
  assign wrEn   = regWr && (regSel == SEL_EN);
  assign wrPrio = regWr && (regSel == SEL_PRIO);
  assign wrAuto = regWr && (regSel == SEL_AUTO);
  assign wrGlb  = regWr && (regSel == SEL_GLOBAL);

  assign glbNow      = wrGlb ? regWrData[0] : globalEn;
  assign glbClearing = wrGlb && globalEn && !regWrData[0];
  assign glbSetting  = wrGlb && regWrData[0];

  assign hiReq = pend & enable & prio  & {NUM_SRC{gateOpen}};
  assign loReq = pend & enable & ~prio & {NUM_SRC{gateOpen}};

  vic_pick #(.WIDTH(NUM_SRC), .IW(IDX_W)) hiPick_i (
    .reqVec(hiReq), .found(hiAny), .idx(hiIdx));
  vic_pick #(.WIDTH(NUM_SRC), .IW(IDX_W)) loPick_i (
    .reqVec(loReq), .found(loAny), .idx(loIdx));

  assign selIdx    = stb.useHi ? hiIdx : loIdx;
  assign irqVector = ADDR_W'(VEC_BASE) + ADDR_W'(VEC_STRIDE) * ADDR_W'(selIdx);

  // Per-source flag update: event wins over clear and software write
  for (genvar g = 0; g < NUM_SRC; g++) begin : gSrc
    assign clrHit[g]   = stb.take && (selIdx == IDX_W'(g)) && autoClr[g];
    assign pendNext[g] = srcEvent[g] |
                         (!clrHit[g] && (wrPend ? regWrData[g] : pend[g]));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend     <= '0;
      enable   <= '0;
      prio     <= '0;
      autoClr  <= '0;
      globalEn <= 1'b0;
    end else begin
      pend <= pendNext;
      if (wrEn)   enable   <= regWrData;
      if (wrPrio) prio     <= regWrData;
      if (wrAuto) autoClr  <= regWrData;
      if (wrGlb)  globalEn <= regWrData[0];
    end
  end

  always_comb begin
    case (regSel)
      SEL_PEND:   regRdData = pend;
      SEL_EN:     regRdData = enable;
      SEL_PRIO:   regRdData = prio;
      SEL_AUTO:   regRdData = autoClr;
      SEL_GLOBAL: regRdData = NUM_SRC'(globalEn);
      default:    regRdData = '0;
    endcase
  end

  // R2: an event always lands in its flag
  p_event_latch_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (|srcEvent) |=> ((pend & $past(srcEvent)) == $past(srcEvent)));

  // R6: a take of a source without auto-clear leaves its flag set
  p_keep_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (stb.take && !autoClr[selIdx] && !wrPend) |=> pend[$past(selIdx)]);
endmodule

// File: rtl/vic_control.sv
module vic_control
  import vic_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       instBoundary,
  input  logic       nextMulti,
  input  logic       retStrobe,
  input  logic       hiAny,
  input  logic       loAny,
  input  logic       glbNow,
  input  logic       glbClearing,
  input  logic       glbSetting,
  output logic       gateOpen,
  output vicStb_t    stb,
  output logic       irqTake,
  output logic [1:0] inService
);
  logic       lateWin;
  logic       hiOk, loOk;
  logic [1:0] inSvc;

  // Clearing the global enable keeps one boundary open unless the next op is long
  assign gateOpen = glbNow || ((lateWin || glbClearing) && !nextMulti);

  assign hiOk    = hiAny && !inSvc[1];
  assign loOk    = loAny && !inSvc[1] && !inSvc[0];
  assign irqTake = instBoundary && !retStrobe && (hiOk || loOk);

  assign stb.take  = irqTake;
  assign stb.useHi = hiOk;
  assign inService = inSvc;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lateWin <= 1'b0;
      inSvc   <= 2'b00;
    end else begin
      if (glbSetting || instBoundary) lateWin <= 1'b0;
      else if (glbClearing)           lateWin <= 1'b1;

      if (retStrobe) begin
        if (inSvc[1]) inSvc[1] <= 1'b0;
        else          inSvc[0] <= 1'b0;
      end else if (irqTake) begin
        if (hiOk) inSvc[1] <= 1'b1;
        else      inSvc[0] <= 1'b1;
      end
    end
  end

  p_take_at_boundary_r3: assert property (@(posedge clk) disable iff (!rst_n)
    irqTake |-> instBoundary);

  p_masked_global_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!glbNow && !lateWin && !glbClearing) |-> !irqTake);

  p_high_blocks_r7: assert property (@(posedge clk) disable iff (!rst_n)
    inSvc[1] |-> !irqTake);

  p_no_take_on_ret_r9: assert property (@(posedge clk) disable iff (!rst_n)
    retStrobe |-> !irqTake);

  p_push_level_r8: assert property (@(posedge clk) disable iff (!rst_n)
    irqTake |=> ($countones(inSvc) == $countones($past(inSvc)) + 1));

  p_pop_level_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (retStrobe && (|inSvc)) |=> ($countones(inSvc) + 1 == $countones($past(inSvc))));
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
  import vic_pkg::*;
#(
  parameter int NUM_SRC    = 8,
  parameter int ADDR_W     = 16,
  parameter int VEC_BASE   = 3,
  parameter int VEC_STRIDE = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] srcEvent,
  input  logic               regWr,
  input  logic [2:0]         regSel,
  input  logic [NUM_SRC-1:0] regWrData,
  output logic [NUM_SRC-1:0] regRdData,
  input  logic               instBoundary,
  input  logic               nextMulti,
  input  logic               retStrobe,
  output logic               irqTake,
  output logic [ADDR_W-1:0]  irqVector,
  output logic [1:0]         inService
);
  vicStb_t stb;
  logic    gateOpen, hiAny, loAny, glbNow, glbClearing, glbSetting;

  vic_datapath #(
    .NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W),
    .VEC_BASE(VEC_BASE), .VEC_STRIDE(VEC_STRIDE)
  ) dp_i (
    .clk(clk), .rst_n(rst_n), .srcEvent(srcEvent),
    .regWr(regWr), .regSel(regSel), .regWrData(regWrData), .regRdData(regRdData),
    .gateOpen(gateOpen), .stb(stb), .hiAny(hiAny), .loAny(loAny),
    .glbNow(glbNow), .glbClearing(glbClearing), .glbSetting(glbSetting),
    .irqVector(irqVector)
  );

  vic_control ctl_i (
    .clk(clk), .rst_n(rst_n), .instBoundary(instBoundary), .nextMulti(nextMulti),
    .retStrobe(retStrobe), .hiAny(hiAny), .loAny(loAny), .glbNow(glbNow),
    .glbClearing(glbClearing), .glbSetting(glbSetting), .gateOpen(gateOpen),
    .stb(stb), .irqTake(irqTake), .inService(inService)
  );
endmodule

// File: tb/prio_irq_ctrl_tb_top.sv
module prio_irq_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  srcEvent = '0;
  logic        regWr = 1'b0;
  logic [2:0]  regSel = '0;
  logic [7:0]  regWrData = '0;
  logic [7:0]  regRdData;
  logic        instBoundary = 1'b0, nextMulti = 1'b0, retStrobe = 1'b0;
  logic        irqTake;
  logic [15:0] irqVector;
  logic [1:0]  inService;

  int checks = 0;
  int failures = 0;

  always #2 clk = ~clk;

  prio_irq_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .srcEvent(srcEvent), .regWr(regWr), .regSel(regSel),
    .regWrData(regWrData), .regRdData(regRdData), .instBoundary(instBoundary),
    .nextMulti(nextMulti), .retStrobe(retStrobe), .irqTake(irqTake),
    .irqVector(irqVector), .inService(inService)
  );

  task automatic chk(input string req, input [31:0] act, input [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic regWrite(input [2:0] sel, input [7:0] data);
    @(negedge clk);
    regWr = 1'b1; regSel = sel; regWrData = data;
    @(negedge clk);
    regWr = 1'b0;
  endtask

  task automatic regRead(input [2:0] sel, output [7:0] data);
    @(negedge clk);
    regSel = sel;
    #1 data = regRdData;
  endtask

  task automatic pulse(input [7:0] mask);
    @(negedge clk);
    srcEvent = mask;
    @(negedge clk);
    srcEvent = '0;
  endtask

  task automatic boundary(input logic multi, input logic ret,
                          output logic took, output [15:0] vec);
    @(negedge clk);
    instBoundary = 1'b1; nextMulti = multi; retStrobe = ret;
    #1 took = irqTake; vec = irqVector;
    @(negedge clk);
    instBoundary = 1'b0; nextMulti = 1'b0; retStrobe = 1'b0;
  endtask

  task automatic t_reset();
    logic [7:0] d;
    doReset();
    for (int s = 0; s < 5; s++) begin
      regRead(3'(s), d);
      chk("R1 register zero after reset", d, 0);
    end
    chk("R1 inService zero", inService, 0);
    chk("R1 take low", irqTake, 0);
  endtask

  task automatic t_latch_and_mask();
    logic took; logic [15:0] v; logic [7:0] d;
    doReset();
    pulse(8'h20);
    regRead(3'd0, d);
    chk("R2 flag set while disabled", d, 8'h20);
    regWrite(3'd4, 8'h01);
    boundary(1'b0, 1'b0, took, v);
    chk("R2 disabled source not taken", took, 0);
    regRead(3'd0, d);
    chk("R2 flag kept while disabled", d, 8'h20);
    regWrite(3'd4, 8'h00);
    regWrite(3'd1, 8'h20);
    boundary(1'b1, 1'b0, took, v);
    boundary(1'b0, 1'b0, took, v);
    chk("R3 global disable masks enabled source", took, 0);
    regWrite(3'd4, 8'h01);
    boundary(1'b0, 1'b0, took, v);
    chk("R3 take with all enables", took, 1);
    chk("R5 vector of source 5", v, 16'h002B);
    regRead(3'd0, d);
    chk("R6 flag kept without auto-clear", d, 8'h20);
    chk("R8 low level in service", inService, 2'b01);
  endtask

  task automatic t_return_rule();
    logic took; logic [15:0] v; logic [7:0] d;
    doReset();
    regWrite(3'd4, 8'h01);
    regWrite(3'd1, 8'h08);
    pulse(8'h08);
    boundary(1'b0, 1'b0, took, v);
    chk("R9 first take", took, 1);
    boundary(1'b0, 1'b1, took, v);
    chk("R9 no take on return cycle", took, 0);
    chk("R8 pop low level", inService, 2'b00);
    boundary(1'b0, 1'b0, took, v);
    chk("R9 retake after one instruction", took, 1);
    chk("R9 vector source 3", v, 16'h001B);
    regRead(3'd0, d);
    chk("R9 flag still pending", d, 8'h08);
  endtask

  task automatic t_sw_set_autoclear();
    logic took; logic [15:0] v; logic [7:0] d;
    doReset();
    regWrite(3'd4, 8'h01);
    regWrite(3'd1, 8'h04);
    regWrite(3'd3, 8'h04);
    regWrite(3'd0, 8'h04);
    regRead(3'd0, d);
    chk("R4 software set flag", d, 8'h04);
    boundary(1'b0, 1'b0, took, v);
    chk("R4 software flag taken", took, 1);
    chk("R5 vector source 2", v, 16'h0013);
    regRead(3'd0, d);
    chk("R6 auto-clear on take", d, 8'h00);
    regWrite(3'd0, 8'h00);
  endtask

  task automatic t_arbitration();
    logic took; logic [15:0] v;
    doReset();
    regWrite(3'd4, 8'h01);
    regWrite(3'd1, 8'hC2);
    regWrite(3'd0, 8'hC2);
    boundary(1'b0, 1'b0, took, v);
    chk("R5 lowest index wins one level", v, 16'h000B);
    doReset();
    regWrite(3'd4, 8'h01);
    regWrite(3'd1, 8'hC2);
    regWrite(3'd2, 8'hC0);
    regWrite(3'd0, 8'hC2);
    boundary(1'b0, 1'b0, took, v);
    chk("R5 high priority wins, lowest high index", v, 16'h0033);
    chk("R8 high level in service", inService, 2'b10);
  endtask

  task automatic t_nesting();
    logic took; logic [15:0] v;
    doReset();
    regWrite(3'd4, 8'h01);
    regWrite(3'd1, 8'h4A);
    regWrite(3'd2, 8'h40);
    regWrite(3'd3, 8'h4A);
    pulse(8'h02);
    boundary(1'b0, 1'b0, took, v);
    chk("R7 low source taken", v, 16'h000B);
    pulse(8'h08);
    boundary(1'b0, 1'b0, took, v);
    chk("R7 low cannot preempt low", took, 0);
    pulse(8'h40);
    boundary(1'b0, 1'b0, took, v);
    chk("R7 high preempts low", took, 1);
    chk("R7 high vector source 6", v, 16'h0033);
    chk("R8 both levels in service", inService, 2'b11);
    pulse(8'h40);
    boundary(1'b0, 1'b0, took, v);
    chk("R7 nothing preempts high", took, 0);
    boundary(1'b0, 1'b1, took, v);
    chk("R8 return pops high first", inService, 2'b01);
    boundary(1'b0, 1'b0, took, v);
    chk("R7 high retaken over low handler", took, 1);
    boundary(1'b0, 1'b1, took, v);
    boundary(1'b0, 1'b1, took, v);
    chk("R8 second return pops low", inService, 2'b00);
  endtask

  task automatic t_window();
    logic took; logic [15:0] v; logic [7:0] d;
    doReset();
    regWrite(3'd1, 8'h01);
    regWrite(3'd4, 8'h01);
    regWrite(3'd0, 8'h01);
    regWrite(3'd4, 8'h00);
    boundary(1'b0, 1'b0, took, v);
    chk("R10 single-cycle next takes in window", took, 1);
    chk("R10 vector source 0", v, 16'h0003);
    doReset();
    regWrite(3'd1, 8'h01);
    regWrite(3'd4, 8'h01);
    regWrite(3'd0, 8'h01);
    @(negedge clk);
    regWr = 1'b1; regSel = 3'd4; regWrData = 8'h00;
    instBoundary = 1'b1; nextMulti = 1'b1;
    #1 chk("R10 clear on boundary, multi-cycle next suppresses", irqTake, 0);
    @(negedge clk);
    regWr = 1'b0; instBoundary = 1'b0; nextMulti = 1'b0;
    boundary(1'b0, 1'b0, took, v);
    chk("R10 window closed after one boundary", took, 0);
    regRead(3'd4, d);
    chk("R11 global reads back 0", d, 0);
  endtask

  task automatic t_readback();
    logic [7:0] d;
    doReset();
    regWrite(3'd1, 8'hA5);
    regWrite(3'd2, 8'h3C);
    regWrite(3'd3, 8'h81);
    regWrite(3'd4, 8'h01);
    regRead(3'd1, d); chk("R11 enable readback", d, 8'hA5);
    regRead(3'd2, d); chk("R11 priority readback", d, 8'h3C);
    regRead(3'd3, d); chk("R11 auto-clear readback", d, 8'h81);
    regRead(3'd4, d); chk("R11 global readback", d, 8'h01);
    regRead(3'd6, d); chk("R11 unused selector reads 0", d, 8'h00);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin : main
    t_reset();
    t_latch_and_mask();
    t_return_rule();
    t_sw_set_autoclear();
    t_arbitration();
    t_nesting();
    t_window();
    t_readback();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule